// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Multiplier

This block multiplies two signed two's-complement operands and returns their full-width product. The work is spread over a fixed chain of registered stages: an input capture stage, two stages that recode the multiplier into radix-4 digits and form the partial-product rows, two stages of 4-to-2 compressors that reduce those rows to a sum row and a carry row, and a conditional-sum adder whose levels each double the block size. For the default 8-bit operands the chain is ten stages long.

Every stage holds a valid flag. A stage takes new data only when it is empty or when the stage after it is handing its contents on in the same cycle. This is a clocked version of a completion handshake. A new operand pair can enter on every cycle while earlier pairs are still in flight. If the consumer stops taking results, the pipeline fills and then holds.

Top module: `booth_mul_pipe`

## Requirements
- R1: For every accepted pair, `prod_o` equals the signed product a × b, both operands two's complement of `W` bits, taken modulo 2^(2·W).
- R2: With the pipeline empty and `out_ready_i` high, a pair accepted at clock edge e makes `out_valid_o` high in the cycle that follows edge e + NS − 1. Here NS = 6 + log2(2·W rounded up to a power of two), which is 10 for W = 8.
- R3: While `out_ready_i` is high, `in_ready_o` is high, so one pair is accepted on every cycle that `in_valid_i` is high.
- R4: Results leave in the same order as the pairs were accepted, and each result leaves exactly once.
- R5: While `out_valid_o` is high and `out_ready_i` is low, the next cycle still shows `out_valid_o` high with `prod_o` unchanged.
- R6: With `out_ready_i` held low, at most NS pairs are accepted before `in_ready_o` drops. When `out_ready_i` rises again, every held pair is delivered.
- R7: During reset and directly after it, `out_valid_o` is low and `in_ready_o` is high.
- R8: Corner pairs are exact, including −128 × −128 = 16384, −128 × 127 = −16256 and 127 × 127 = 16129.
- R9: Cycles with `in_valid_i` low produce no result. The number of results equals the number of accepted pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand pair present |
| in_ready_o | output | 1 | Pipeline takes the pair at this edge |
| a_i | input | W | Multiplicand, two's complement |
| b_i | input | W | Multiplier, two's complement |
| out_valid_o | output | 1 | Product present |
| out_ready_i | input | 1 | Consumer takes the product at this edge |
| prod_o | output | 2·W | Signed product |

## Verification
A fault in the Booth recoding, in the compressor arithmetic or in the carry selection of the adder shows up as a wrong `prod_o` exactly NS cycles after the faulty pair was accepted. Corner operands at the negative limit reach the most sign-sensitive paths. A fault in the valid chain shows up in other ways: a wrong latency, a lost or duplicated result, a result out of order, or a held product that changes while the consumer stalls. The scoreboard sees each of these at the first result that comes after the fault.

// File: rtl/booth_mul_pkg.sv
package booth_mul_pkg;

  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_dig_t;

  // radix-4 recoding of {b[2j+1], b[2j], b[2j-1]}
  function automatic booth_dig_t booth_enc(input logic [2:0] t);
    booth_dig_t d;
    d.neg = t[2];
    d.one = t[1] ^ t[0];
    d.two = (~t[2] & t[1] & t[0]) | (t[2] & ~t[1] & ~t[0]);
    return d;
  endfunction

endpackage

// File: rtl/mul_pipe_ctl.sv
module mul_pipe_ctl #(
  parameter int NS = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [NS-1:0] en_o
);

  logic [NS-1:0] v_q;
  logic [NS-1:0] rdy;
  logic [NS-1:0] vin;

  // a stage may load when it or any stage downstream has room
  for (genvar k = 0; k < NS; k++) begin : g_rdy
    assign rdy[k] = out_ready_i | ~(&v_q[NS-1:k]);
  end

  assign vin = {v_q[NS-2:0], in_valid_i};
  assign en_o = rdy & vin;
  assign in_ready_o = rdy[0];
  assign out_valid_o = v_q[NS-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q <= '0;
    end else begin
      for (int k = 0; k < NS; k++) begin
        if (rdy[k]) v_q[k] <= vin[k];
      end
    end
  end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_mul_pkg::*;
#(
  parameter int W   = 8,
  parameter int NPP = W / 2 + 1,
  parameter int PW  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [1:0]               en_i,
  input  logic [W-1:0]             a_i,
  input  logic [W-1:0]             b_i,
  output logic [NPP-1:0][PW-1:0]   pp_o
);

  localparam int BX = 2 * NPP;

  logic [BX:0]              bext;
  logic [W-1:0]             a_q;
  booth_dig_t [NPP-1:0]     dig_q;
  logic [PW-1:0]            a_se;
  logic [NPP-1:0][PW-1:0]   pp_q;

  assign bext = {{(BX - W){b_i[W-1]}}, b_i, 1'b0};
  assign a_se = {{(PW - W){a_q[W-1]}}, a_q};

  function automatic logic [PW-1:0] pp_row(input booth_dig_t d, input logic [PW-1:0] x);
    logic [PW-1:0] m;
    m = d.two ? (x << 1) : (d.one ? x : '0);
    return d.neg ? (~m + PW'(1)) : m;
  endfunction

  // stage: recode
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      dig_q <= '0;
    end else if (en_i[0]) begin
      a_q <= a_i;
      for (int j = 0; j < NPP; j++) dig_q[j] <= booth_enc(bext[2*j +: 3]);
    end
  end

  // stage: weighted partial-product rows
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pp_q <= '0;
    end else if (en_i[1]) begin
      for (int j = 0; j < NPP; j++) pp_q[j] <= pp_row(dig_q[j], a_se) << (2 * j);
    end
  end

  assign pp_o = pp_q;

endmodule

// File: rtl/csa42_tree.sv
module csa42_tree #(
  parameter int NPP = 5,  // at most 8 rows
  parameter int PW  = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [1:0]             en_i,
  input  logic [NPP-1:0][PW-1:0] rows_i,
  output logic [PW-1:0]          sum_o,
  output logic [PW-1:0]          car_o
);

  logic [7:0][PW-1:0] r8;
  logic [3:0][PW-1:0] l1_q;
  logic [PW-1:0]      sum_q, car_q;

  for (genvar i = 0; i < 8; i++) begin : g_pad
    if (i < NPP) begin : g_row
      assign r8[i] = rows_i[i];
    end else begin : g_zero
      assign r8[i] = '0;
    end
  end

  // x1+x2+x3+x4 == s + c (mod 2^PW); returns {c, s}
  function automatic logic [1:0][PW-1:0] c42(input logic [PW-1:0] x1, x2, x3, x4);
    logic [PW-1:0] s1, ci, s, c;
    s1 = x1 ^ x2 ^ x3;
    ci = ((x1 & x2) | (x1 & x3) | (x2 & x3)) << 1;
    s  = s1 ^ x4 ^ ci;
    c  = ((s1 & x4) | (s1 & ci) | (x4 & ci)) << 1;
    return {c, s};
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_q <= '0;
    end else if (en_i[0]) begin
      {l1_q[1], l1_q[0]} <= c42(r8[0], r8[1], r8[2], r8[3]);
      {l1_q[3], l1_q[2]} <= c42(r8[4], r8[5], r8[6], r8[7]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      car_q <= '0;
    end else if (en_i[1]) begin
      {car_q, sum_q} <= c42(l1_q[0], l1_q[1], l1_q[2], l1_q[3]);
    end
  end

  assign sum_o = sum_q;
  assign car_o = car_q;

endmodule

// File: rtl/cond_sum_adder.sv
module cond_sum_adder #(
  parameter int PW = 16,  // power of two
  parameter int LV = $clog2(PW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [LV:0]   en_i,
  input  logic [PW-1:0] x_i,
  input  logic [PW-1:0] y_i,
  output logic [PW-1:0] sum_o
);

  // new block size b: low half copied from slow, high half picked by the low-half carry
  function automatic logic [PW-1:0] merge_sum(input int b, input logic [PW-1:0] s0,
                                              input logic [PW-1:0] s1, input logic [PW-1:0] slow,
                                              input logic [PW-1:0] cl);
    logic [PW-1:0] r;
    for (int i = 0; i < PW; i++) begin
      if ((i % b) >= (b / 2)) r[i] = cl[2 * (i / b)] ? s1[i] : s0[i];
      else                    r[i] = slow[i];
    end
    return r;
  endfunction

  function automatic logic [PW-1:0] merge_car(input int b, input logic [PW-1:0] c0,
                                              input logic [PW-1:0] c1, input logic [PW-1:0] cl);
    logic [PW-1:0] r;
    r = '0;
    for (int k = 0; k < PW / 2; k++) begin
      if (k < PW / b) r[k] = cl[2*k] ? c1[2*k+1] : c0[2*k+1];
    end
    return r;
  endfunction

  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int B = 1 << l;
    logic [PW-1:0] s0_q;

    if (l == 0) begin : g_base
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s0_q <= '0;
        else if (en_i[0]) s0_q <= x_i ^ y_i;
      end
    end else begin : g_mrg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s0_q <= '0;
        else if (en_i[l])
          s0_q <= merge_sum(B, g_lvl[l-1].s0_q, g_lvl[l-1].g_c.s1_q,
                            g_lvl[l-1].s0_q, g_lvl[l-1].g_c.c0_q);
      end
    end

    // carry-in-one sums and both carries, not needed after the last level
    if (l < LV) begin : g_c
      logic [PW-1:0] s1_q, c0_q, c1_q;
      if (l == 0) begin : g_base
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            s1_q <= '0; c0_q <= '0; c1_q <= '0;
          end else if (en_i[0]) begin
            s1_q <= ~(x_i ^ y_i);
            c0_q <= x_i & y_i;
            c1_q <= x_i | y_i;
          end
        end
      end else begin : g_mrg
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) begin
            s1_q <= '0; c0_q <= '0; c1_q <= '0;
          end else if (en_i[l]) begin
            s1_q <= merge_sum(B, g_lvl[l-1].s0_q, g_lvl[l-1].g_c.s1_q,
                              g_lvl[l-1].g_c.s1_q, g_lvl[l-1].g_c.c1_q);
            c0_q <= merge_car(B, g_lvl[l-1].g_c.c0_q, g_lvl[l-1].g_c.c1_q, g_lvl[l-1].g_c.c0_q);
            c1_q <= merge_car(B, g_lvl[l-1].g_c.c0_q, g_lvl[l-1].g_c.c1_q, g_lvl[l-1].g_c.c1_q);
          end
        end
      end
    end
  end

  assign sum_o = g_lvl[LV].s0_q;

endmodule

// File: rtl/booth_mul_pipe.sv
module booth_mul_pipe #(
  parameter int W = 8  // even, 4..14
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           in_valid_i,
  output logic           in_ready_o,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           out_valid_o,
  input  logic           out_ready_i,
  output logic [2*W-1:0] prod_o
);

  localparam int PW  = 1 << $clog2(2 * W);
  localparam int LV  = $clog2(PW);
  localparam int NPP = W / 2 + 1;
  localparam int NS  = 6 + LV;

  logic [NS-1:0]          en;
  logic [W-1:0]           a0_q, b0_q;
  logic [NPP-1:0][PW-1:0] pp;
  logic [PW-1:0]          row_s, row_c, sum;

  mul_pipe_ctl #(.NS(NS)) u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .in_ready_o (in_ready_o),
    .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i),
    .en_o       (en)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a0_q <= '0;
      b0_q <= '0;
    end else if (en[0]) begin
      a0_q <= a_i;
      b0_q <= b_i;
    end
  end

  booth_pp_gen #(.W(W), .NPP(NPP), .PW(PW)) u_pp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en[2:1]),
    .a_i   (a0_q),
    .b_i   (b0_q),
    .pp_o  (pp)
  );

  csa42_tree #(.NPP(NPP), .PW(PW)) u_csa (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en[4:3]),
    .rows_i(pp),
    .sum_o (row_s),
    .car_o (row_c)
  );

  cond_sum_adder #(.PW(PW), .LV(LV)) u_add (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en[NS-1:5]),
    .x_i   (row_s),
    .y_i   (row_c),
    .sum_o (sum)
  );

  assign prod_o = sum[2*W-1:0];

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
  parameter int W  = 8,
  parameter int NS = 10
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           in_valid_i,
  input logic           in_ready_o,
  input logic           out_valid_o,
  input logic           out_ready_i,
  input logic [2*W-1:0] prod_o
);

  localparam int CW = $clog2(NS + 1) + 1;

  logic          in_fire, out_fire;
  logic [CW-1:0] cnt_q;

  assign in_fire  = in_valid_i & in_ready_o;
  assign out_fire = out_valid_o & out_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(in_fire) - CW'(out_fire);
  end

  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(prod_o));

  assert_flow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_ready_i |-> in_ready_o);

  assert_occupancy_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NS));

  assert_full_block_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(NS)) && !out_ready_i |-> !in_ready_o);

  assert_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> cnt_q != '0);

  assert_idle_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> in_ready_o);

endmodule

bind booth_mul_pipe booth_mul_chk #(.W(W), .NS(NS)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_valid_i (in_valid_i),
  .in_ready_o (in_ready_o),
  .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i),
  .prod_o     (prod_o)
);

// File: tb/booth_mul_pipe_tb_top.sv
`timescale 1ns/1ps
module booth_mul_pipe_tb_top;

  localparam int W   = 8;
  localparam int LAT = 6 + $clog2(2 * W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0]   a_in = '0, b_in = '0;
  logic           in_ready, out_valid;
  logic [2*W-1:0] prod;

  booth_mul_pipe #(.W(W)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .in_valid_i (in_valid),
    .in_ready_o (in_ready),
    .a_i        (a_in),
    .b_i        (b_in),
    .out_valid_o(out_valid),
    .out_ready_i(out_ready),
    .prod_o     (prod)
  );

  int checks = 0, errors = 0, n_in = 0, n_out = 0;
  logic [2*W-1:0] exp_q[$];
  logic [2*W-1:0] e_pop;
  bit finished = 0;

  function automatic logic [2*W-1:0] exp_prod(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] sa, sb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return sa * sb;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic iv, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic ordy, output logic acc, output logic ov,
                      output logic [2*W-1:0] pr);
    @(negedge clk);
    in_valid = iv; a_in = a; b_in = b; out_ready = ordy;
    #1;
    acc = iv && in_ready;
    ov  = out_valid;
    pr  = prod;
    if (acc) begin
      exp_q.push_back(exp_prod(a, b));
      n_in++;
    end
    @(posedge clk);
  endtask

  // monitor: pops the scoreboard on every output handshake
  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "result with nothing pending", 1, 0);
        end else begin
          e_pop = exp_q.pop_front();
          check(prod == e_pop, "R1 R4", "product", prod, e_pop);
        end
        n_out++;
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #1_200_000;
    check(0, "R4", "watchdog expired", 0, 1);
    finish_run();
  end

  logic acc, ov;
  logic [2*W-1:0] pr, p_hold;
  int lat, cnt, spurious;
  logic [W-1:0] ca [12] = '{8'h80, 8'h80, 8'h7f, 8'h7f, 8'h00, 8'hff, 8'h01, 8'h55, 8'h80, 8'hc0, 8'h3f, 8'hfe};
  logic [W-1:0] cb [12] = '{8'h80, 8'h7f, 8'h7f, 8'h80, 8'h80, 8'hff, 8'hff, 8'haa, 8'h01, 8'h40, 8'h81, 8'h02};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R7", "in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R7", "out_valid after reset", out_valid, 0);
    check(in_ready == 1'b1, "R7", "in_ready after reset", in_ready, 1);

    // R2 latency on an empty pipe, with the R8 corner -128 * -128
    step(1, 8'h80, 8'h80, 1, acc, ov, pr);
    check(acc == 1'b1, "R2", "first pair accepted", acc, 1);
    lat = 0;
    for (int i = 1; i <= LAT + 6; i++) begin
      step(0, '0, '0, 1, acc, ov, pr);
      if (ov && lat == 0) begin
        lat = i;
        check(pr == 16'd16384, "R8", "-128*-128", pr, 16384);
      end
    end
    check(lat == LAT, "R2", "latency", lat, LAT);

    // R3 R8 back-to-back corner pairs
    cnt = 0;
    foreach (ca[i]) begin
      step(1, ca[i], cb[i], 1, acc, ov, pr);
      if (acc) cnt++;
    end
    check(cnt == 12, "R3", "back-to-back accepts", cnt, 12);
    repeat (LAT + 4) step(0, '0, '0, 1, acc, ov, pr);

    // R1 R4 random operands, gaps and random consumer stalls
    for (int n = 0; n < 1500; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      if ($urandom % 4 == 0) step(0, '0, '0, 1'($urandom % 5 != 0), acc, ov, pr);
      acc = 1'b0;
      while (!acc) step(1, ra, rb, 1'($urandom % 5 != 0), acc, ov, pr);
    end
    repeat (LAT + 4) step(0, '0, '0, 1, acc, ov, pr);
    check(n_out == n_in, "R9", "results equal accepted pairs", n_out, n_in);
    check(exp_q.size() == 0, "R4", "scoreboard empty", exp_q.size(), 0);

    // R9 idle cycles produce nothing
    spurious = 0;
    repeat (20) begin
      step(0, 8'h12, 8'h34, 1, acc, ov, pr);
      if (ov) spurious++;
    end
    check(spurious == 0, "R9", "outputs while idle", spurious, 0);

    // R6 back-pressure fill
    cnt = 0;
    for (int i = 0; i < 3 * LAT; i++) begin
      step(1, W'($urandom), W'($urandom), 0, acc, ov, pr);
      if (acc) cnt++;
    end
    check(cnt == LAT, "R6", "accepted while blocked", cnt, LAT);
    check(in_ready == 1'b0, "R6", "in_ready when full", in_ready, 0);

    // R5 hold under stall
    step(0, '0, '0, 0, acc, ov, p_hold);
    repeat (5) step(0, '0, '0, 0, acc, ov, pr);
    check(ov == 1'b1, "R5", "valid held", ov, 1);
    check(pr == p_hold, "R5", "product held", pr, p_hold);

    repeat (LAT + 4) step(0, '0, '0, 1, acc, ov, pr);
    check(n_out == n_in, "R6", "all held pairs delivered", n_out, n_in);
    check(exp_q.size() == 0, "R4", "scoreboard empty at end", exp_q.size(), 0);

    finish_run();
  end

endmodule